// File: doc/BRIEF.md
# Peripheral DMA Channel with Reload Buffer

This block is a single channel of a DMA engine that moves data items between a peripheral and memory. Software programs a live memory address, a live item count, a peripheral selection, an item size and a direction through a small register port. Each request from the selected peripheral causes exactly one transfer on a valid/ready memory port. When that transfer completes, the address advances by the item size, the count drops by one, and the peripheral receives a one-cycle acknowledge.

A second address/count pair acts as a standby buffer. When the live count runs out and the standby count is nonzero, the standby pair becomes the live pair and the standby count is cleared. Software can then refill the standby pair while the channel works through the live buffer, so a stream can continue across two alternating buffers without stalling. A sticky terminal-count flag and a standby-empty flag each drive a maskable interrupt line.

Top module: `pdc_channel`

## Requirements
- R1: After reset the live address, live count, standby address, standby count, control and mask registers read zero, the status register reads 2 (standby empty), and `mem_valid`, `p_ack`, `irq_tc` and `irq_rld` are low.
- R2: When the channel is enabled, idle, its live count is nonzero and `p_req[sel]` is high at a clock edge, `mem_valid` is high from that edge on with `mem_addr` equal to the live address and `mem_write` equal to the inverse of the direction bit. When writing, `mem_wdata` carries slice `sel` of `p_wdata`. Direction 0 means peripheral to memory (write) and direction 1 means memory to peripheral (read).
- R3: While `mem_valid` is high and `mem_ready` is low, the request and its address, direction and write data hold steady. At most one transfer is outstanding, so `mem_valid` is low in the cycle after a completion.
- R4: In the completion cycle (`mem_valid` and `mem_ready` both high), `p_ack` is one-hot at the selected peripheral and `p_rdata` equals `mem_rdata`. At that edge the live count drops by one and the live address grows by the size step. Size code 0 steps 1, code 1 steps 2, codes 2 and 3 step 4.
- R5: A request is ignored while the enable bit is clear, while the live count is zero, or when it arrives on a line other than the selected one. In these cases no memory request is issued and the live count is unchanged.
- R6: At any edge where the live count is zero, or is brought to zero by a completion, and the standby count is nonzero, the live address and live count take the standby values and the standby count becomes zero.
- R7: When the live count and standby count are both zero, no transfer is issued, whatever requests arrive.
- R8: Status bit 0 is a sticky flag, set by a completion that brings the live count from 1 to 0 (even if a reload follows) and cleared by a write to the live count register. Status bit 1 reads 1 exactly when the standby count is zero.
- R9: `irq_tc` equals status bit 0 AND mask bit 0, and `irq_rld` equals status bit 1 AND mask bit 1.
- R10: The register port reads the live address and count at any time, including while a transfer is pending. The register codes are 0 live address, 1 live count, 2 standby address, 3 standby count, 4 control (bit 0 enable, bits 2:1 size, bit 3 direction, bits 4 and up select), 5 status and 6 mask.
- R11: When a software write and a completion fall on the same edge, the written register takes the software value, and every other register still takes its hardware update (address step, reload, flag set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register code |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for `reg_addr` (combinational) |
| p_req | input | NP | Handshake request lines, one per peripheral |
| p_wdata | input | NP*DW | Data from each peripheral, slice i belongs to peripheral i |
| p_ack | output | NP | One-cycle completion acknowledge per peripheral |
| p_rdata | output | DW | Data read from memory, delivered to the peripheral |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts and completes the request |
| mem_write | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with `mem_ready` |
| irq_tc | output | 1 | Terminal-count interrupt |
| irq_rld | output | 1 | Standby-empty interrupt |

## Verification
Two pairs of updates can land on the same edge: a completion together with the reload swap, and a completion together with a software write to a count register. The sweep reaches the first pair naturally by running every configuration to exhaustion with standby counts of 0, 1 and 2. Two directed transfers raise `reg_wr` in the very cycle `mem_ready` is high, once to the live count and once to the standby count while a swap consumes the old standby value. Each outcome is judged by reading back the live address, both counts and the status, and comparing them with an arithmetic model that applies the hardware update first and then the software override.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  localparam logic [2:0] RA_ADDR  = 3'd0;
  localparam logic [2:0] RA_CNT   = 3'd1;
  localparam logic [2:0] RA_RADDR = 3'd2;
  localparam logic [2:0] RA_RCNT  = 3'd3;
  localparam logic [2:0] RA_CTRL  = 3'd4;
  localparam logic [2:0] RA_STAT  = 3'd5;
  localparam logic [2:0] RA_MASK  = 3'd6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } item_size_e;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_BUSY = 1'b1
  } eng_state_e;

  function automatic logic [2:0] size_step(item_size_e sz);
    case (sz)
      SZ_BYTE: size_step = 3'd1;
      SZ_HALF: size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pdc_regs.sv
module pdc_regs
  import pdc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [2:0]      reg_addr,
  input  logic [AW-1:0]   reg_wdata,
  output logic [AW-1:0]   reg_rdata,
  input  logic            xfer_done,
  input  logic [2:0]      xfer_inc,
  output logic [AW-1:0]   live_addr,
  output logic [CW-1:0]   live_cnt,
  output logic [CW-1:0]   rld_cnt,
  output logic            ch_en,
  output item_size_e      ch_size,
  output logic            ch_dir,
  output logic [SELW-1:0] ch_sel,
  output logic            irq_tc,
  output logic            irq_rld
);

  localparam int CPAD = AW - CW;

  logic [AW-1:0]   addr_q, addr_n, raddr_q, raddr_n;
  logic [CW-1:0]   cnt_q, cnt_n, rcnt_q, rcnt_n;
  logic            tc_q, tc_n;
  logic            en_q, dir_q;
  item_size_e      size_q;
  logic [SELW-1:0] sel_q;
  logic [1:0]      mask_q;
  logic [CW-1:0]   dec_cnt;
  logic            swap;

  logic addr_ce, cnt_ce, raddr_ce, rcnt_ce, tc_ce, ctrl_ce, mask_ce;

  // next-state: hardware update first, software write overrides last
  always_comb begin
    addr_n  = addr_q;
    cnt_n   = cnt_q;
    raddr_n = raddr_q;
    rcnt_n  = rcnt_q;
    tc_n    = tc_q;
    dec_cnt = cnt_q;
    if (xfer_done) begin
      addr_n = addr_q + {{(AW-3){1'b0}}, xfer_inc};
      if (cnt_q != '0) dec_cnt = cnt_q - {{(CW-1){1'b0}}, 1'b1};
      cnt_n = dec_cnt;
      if (cnt_q == {{(CW-1){1'b0}}, 1'b1}) tc_n = 1'b1;
    end
    swap = (cnt_n == '0) && (rcnt_q != '0);
    if (swap) begin
      addr_n = raddr_q;
      cnt_n  = rcnt_q;
      rcnt_n = '0;
    end
    if (reg_wr) begin
      case (reg_addr)
        RA_ADDR:  addr_n  = reg_wdata;
        RA_CNT:   begin cnt_n = reg_wdata[CW-1:0]; tc_n = 1'b0; end
        RA_RADDR: raddr_n = reg_wdata;
        RA_RCNT:  rcnt_n  = reg_wdata[CW-1:0];
        default:  ;
      endcase
    end
  end

  assign addr_ce  = xfer_done | swap | (reg_wr && reg_addr == RA_ADDR);
  assign cnt_ce   = xfer_done | swap | (reg_wr && reg_addr == RA_CNT);
  assign raddr_ce = reg_wr && reg_addr == RA_RADDR;
  assign rcnt_ce  = swap | (reg_wr && reg_addr == RA_RCNT);
  assign tc_ce    = xfer_done | (reg_wr && reg_addr == RA_CNT);
  assign ctrl_ce  = reg_wr && reg_addr == RA_CTRL;
  assign mask_ce  = reg_wr && reg_addr == RA_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      raddr_q <= '0;
      rcnt_q  <= '0;
      tc_q    <= 1'b0;
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      size_q  <= SZ_BYTE;
      sel_q   <= '0;
      mask_q  <= '0;
    end else begin
      if (addr_ce)  addr_q  <= addr_n;
      if (cnt_ce)   cnt_q   <= cnt_n;
      if (raddr_ce) raddr_q <= raddr_n;
      if (rcnt_ce)  rcnt_q  <= rcnt_n;
      if (tc_ce)    tc_q    <= tc_n;
      if (ctrl_ce) begin
        en_q   <= reg_wdata[0];
        size_q <= item_size_e'(reg_wdata[2:1]);
        dir_q  <= reg_wdata[3];
        sel_q  <= reg_wdata[4 +: SELW];
      end
      if (mask_ce)  mask_q  <= reg_wdata[1:0];
    end
  end

  // read side
  logic [AW-1:0] ctrl_view, stat_view, mask_view;
  always_comb begin
    ctrl_view = '0;
    ctrl_view[0] = en_q;
    ctrl_view[2:1] = size_q;
    ctrl_view[3] = dir_q;
    ctrl_view[4 +: SELW] = sel_q;
    stat_view = '0;
    stat_view[0] = tc_q;
    stat_view[1] = (rcnt_q == '0);
    mask_view = '0;
    mask_view[1:0] = mask_q;
    case (reg_addr)
      RA_ADDR:  reg_rdata = addr_q;
      RA_CNT:   reg_rdata = {{CPAD{1'b0}}, cnt_q};
      RA_RADDR: reg_rdata = raddr_q;
      RA_RCNT:  reg_rdata = {{CPAD{1'b0}}, rcnt_q};
      RA_CTRL:  reg_rdata = ctrl_view;
      RA_STAT:  reg_rdata = stat_view;
      RA_MASK:  reg_rdata = mask_view;
      default:  reg_rdata = '0;
    endcase
  end

  assign live_addr = addr_q;
  assign live_cnt  = cnt_q;
  assign rld_cnt   = rcnt_q;
  assign ch_en     = en_q;
  assign ch_size   = size_q;
  assign ch_dir    = dir_q;
  assign ch_sel    = sel_q;
  assign irq_tc    = tc_q & mask_q[0];
  assign irq_rld   = (rcnt_q == '0) & mask_q[1];

endmodule

// File: rtl/pdc_xfer.sv
module pdc_xfer
  import pdc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NP   = 4,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ch_en,
  input  logic            cnt_nz,
  input  logic [SELW-1:0] ch_sel,
  input  item_size_e      ch_size,
  input  logic            ch_dir,
  input  logic [AW-1:0]   live_addr,
  input  logic [NP-1:0]   p_req,
  input  logic [NP*DW-1:0] p_wdata,
  output logic [NP-1:0]   p_ack,
  output logic [DW-1:0]   p_rdata,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            xfer_done,
  output logic [2:0]      xfer_inc
);

  eng_state_e      st_q, st_n;
  logic [AW-1:0]   a_q;
  logic [DW-1:0]   d_q;
  logic            w_q;
  logic [SELW-1:0] s_q;
  logic [2:0]      inc_q;
  logic            start, done, sel_req, cap_ce;

  assign sel_req = p_req[ch_sel];
  assign start   = (st_q == ENG_IDLE) && ch_en && cnt_nz && sel_req;
  assign done    = (st_q == ENG_BUSY) && mem_ready;
  assign cap_ce  = start;

  always_comb begin
    st_n = st_q;
    case (st_q)
      ENG_IDLE: if (start) st_n = ENG_BUSY;
      ENG_BUSY: if (done)  st_n = ENG_IDLE;
      default:  st_n = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      a_q   <= '0;
      d_q   <= '0;
      w_q   <= 1'b0;
      s_q   <= '0;
      inc_q <= 3'd1;
    end else begin
      st_q <= st_n;
      if (cap_ce) begin
        a_q   <= live_addr;
        d_q   <= p_wdata[ch_sel*DW +: DW];
        w_q   <= ~ch_dir;
        s_q   <= ch_sel;
        inc_q <= size_step(ch_size);
      end
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_ack
    assign p_ack[i] = done && (s_q == SELW'(i));
  end

  assign p_rdata   = mem_rdata;
  assign mem_valid = (st_q == ENG_BUSY);
  assign mem_write = w_q;
  assign mem_addr  = a_q;
  assign mem_wdata = d_q;
  assign xfer_done = done;
  assign xfer_inc  = inc_q;

endmodule

// File: rtl/pdc_channel.sv
module pdc_channel
  import pdc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NP = 4,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  input  logic [NP-1:0]    p_req,
  input  logic [NP*DW-1:0] p_wdata,
  output logic [NP-1:0]    p_ack,
  output logic [DW-1:0]    p_rdata,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_write,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             irq_tc,
  output logic             irq_rld
);

  localparam int SELW = (NP > 1) ? $clog2(NP) : 1;

  logic [AW-1:0]   live_addr;
  logic [CW-1:0]   live_cnt, rld_cnt;
  logic            ch_en, ch_dir, xfer_done;
  item_size_e      ch_size;
  logic [SELW-1:0] ch_sel;
  logic [2:0]      xfer_inc;

  pdc_regs #(.AW(AW), .CW(CW), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_done(xfer_done), .xfer_inc(xfer_inc),
    .live_addr(live_addr), .live_cnt(live_cnt), .rld_cnt(rld_cnt),
    .ch_en(ch_en), .ch_size(ch_size), .ch_dir(ch_dir), .ch_sel(ch_sel),
    .irq_tc(irq_tc), .irq_rld(irq_rld)
  );

  pdc_xfer #(.AW(AW), .DW(DW), .NP(NP), .SELW(SELW)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .ch_en(ch_en), .cnt_nz(live_cnt != '0), .ch_sel(ch_sel), .ch_size(ch_size),
    .ch_dir(ch_dir), .live_addr(live_addr),
    .p_req(p_req), .p_wdata(p_wdata), .p_ack(p_ack), .p_rdata(p_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .xfer_done(xfer_done), .xfer_inc(xfer_inc)
  );

endmodule

// File: rtl/pdc_channel_chk.sv
module pdc_channel_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NP = 4,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [NP-1:0] p_ack,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          ch_en,
  input logic          xfer_done,
  input logic [CW-1:0] live_cnt,
  input logic [CW-1:0] rld_cnt
);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata));

  assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready |=> !mem_valid);

  assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(p_ack));

  assert_ack_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|p_ack) |-> mem_valid && mem_ready);

  assert_count_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && live_cnt > {{(CW-1){1'b0}}, 1'b1} && !reg_wr
    |=> live_cnt == $past(live_cnt) - {{(CW-1){1'b0}}, 1'b1});

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(ch_en) && $past(live_cnt) != '0);

  assert_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && live_cnt == {{(CW-1){1'b0}}, 1'b1} && rld_cnt != '0 && !reg_wr
    |=> live_cnt == $past(rld_cnt) && rld_cnt == '0);

  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live_cnt == '0 && rld_cnt == '0 && !mem_valid |=> !mem_valid);

  logic unused_ok;
  assign unused_ok = ^reg_addr;

endmodule

bind pdc_channel pdc_channel_chk #(.AW(AW), .DW(DW), .NP(NP), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .p_ack(p_ack),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ch_en(ch_en), .xfer_done(xfer_done),
  .live_cnt(live_cnt), .rld_cnt(rld_cnt)
);

// File: tb/test_pdc_channel.sv
`timescale 1ns/1ps
module test_pdc_channel;

  localparam int AW = 32, DW = 32, NP = 4, CW = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             reg_wr;
  logic [2:0]       reg_addr;
  logic [AW-1:0]    reg_wdata, reg_rdata;
  logic [NP-1:0]    p_req, p_ack;
  logic [NP*DW-1:0] p_wdata;
  logic [DW-1:0]    p_rdata, mem_wdata, mem_rdata;
  logic             mem_valid, mem_ready, mem_write, irq_tc, irq_rld;
  logic [AW-1:0]    mem_addr;

  pdc_channel #(.AW(AW), .DW(DW), .NP(NP), .CW(CW)) i_pdc_channel (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [31:0] m_addr, m_raddr;
  int m_cnt, m_rc, m_sz, m_dir, m_sel;
  bit m_tc;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
    case (a)
      3'd0: m_addr = d;
      3'd1: begin m_cnt = int'(d[CW-1:0]); m_tc = 1'b0; end
      3'd2: m_raddr = d;
      3'd3: m_rc = int'(d[CW-1:0]);
      default: ;
    endcase
  endtask

  task automatic check_state(input string tag);
    logic [31:0] v;
    rd(3'd0, v); chk({tag, " live address"}, v, m_addr);
    rd(3'd1, v); chk({tag, " live count"}, v, m_cnt);
    rd(3'd3, v); chk({tag, " standby count"}, v, m_rc);
    rd(3'd5, v); chk({"R8 status after ", tag}, v, {30'd0, m_rc == 0, m_tc});
  endtask

  // one transfer; optional software write landing on the completion edge (R11)
  task automatic do_xfer(input int lat, input bit col, input logic [2:0] wa, input logic [31:0] wd);
    logic [31:0] pd, rv, v;
    int inc;
    inc = (m_sz == 0) ? 1 : (m_sz == 1) ? 2 : 4;
    pd = 32'hD000_0000 ^ m_addr;
    rv = 32'h5A00_0000 ^ m_addr;
    p_wdata = {NP{32'hEEEE_EEEE}};
    p_wdata[m_sel*DW +: DW] = pd;
    p_req = '0; p_req[m_sel] = 1'b1;
    step();
    p_req = '0;
    chk("R2 request issued", mem_valid, 1);
    chk("R2 address", mem_addr, m_addr);
    chk("R2 direction", mem_write, (m_dir == 0));
    if (m_dir == 0) chk("R2 write data", mem_wdata, pd);
    rd(3'd1, v); chk("R10 count mid-transfer", v, m_cnt);
    rd(3'd0, v); chk("R10 address mid-transfer", v, m_addr);
    for (int i = 0; i < lat; i++) begin
      step();
      chk("R3 hold while not ready", {mem_valid, mem_addr}, {1'b1, m_addr});
    end
    mem_ready = 1'b1; mem_rdata = rv;
    if (col) begin reg_wr = 1'b1; reg_addr = wa; reg_wdata = wd; end
    #1;
    chk("R4 acknowledge", p_ack, 64'(1) << m_sel);
    chk("R4 read data", p_rdata, rv);
    step();
    mem_ready = 1'b0; reg_wr = 1'b0;
    if (m_cnt == 1) m_tc = 1'b1;
    m_addr = m_addr + inc;
    if (m_cnt != 0) m_cnt--;
    if (m_cnt == 0 && m_rc != 0) begin m_addr = m_raddr; m_cnt = m_rc; m_rc = 0; end
    if (col) begin
      case (wa)
        3'd0: m_addr = wd;
        3'd1: begin m_cnt = int'(wd[CW-1:0]); m_tc = 1'b0; end
        3'd2: m_raddr = wd;
        3'd3: m_rc = int'(wd[CW-1:0]);
        default: ;
      endcase
    end
    chk("R3 single outstanding", mem_valid, 0);
    check_state(col ? "R11 collision" : "R4/R6 completion");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog all-requirements act=timeout exp=finished");
    report();
  end

  initial begin : main
    logic [31:0] v;
    int k;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    p_req = '0; p_wdata = '0; mem_ready = 1'b0; mem_rdata = '0;
    m_addr = 0; m_raddr = 0; m_cnt = 0; m_rc = 0; m_tc = 0; m_sz = 0; m_dir = 0; m_sel = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, (a == 5) ? 2 : 0);
    end
    chk("R1 reset outputs", {mem_valid, p_ack, irq_tc, irq_rld}, 0);

    // R5 disabled channel ignores requests
    wr(3'd1, 32'd3);
    p_req = '1; step(); step(); p_req = '0;
    chk("R5 disabled ignores request", mem_valid, 0);
    rd(3'd1, v); chk("R5 count untouched when disabled", v, 3);
    wr(3'd1, 32'd0);

    // sweep: size x direction x select, each run to exhaustion
    for (int sz = 0; sz < 4; sz++)
      for (int dir = 0; dir < 2; dir++)
        for (int sel = 0; sel < NP; sel++) begin
          m_sz = sz; m_dir = dir; m_sel = sel;
          wr(3'd4, 32'd0);
          wr(3'd0, 32'h1000 + sel * 32'h100 + sz * 32'h10);
          wr(3'd1, 32'(1 + sel % 2));
          wr(3'd2, 32'h8000 + sel * 32'h40 + dir * 32'h400);
          wr(3'd3, 32'((sz + dir) % 3));
          wr(3'd4, {26'd0, 2'(sel), 1'(dir), 2'(sz), 1'b1});
          check_state("R8 setup");
          p_req = '0; p_req[(sel + 1) % NP] = 1'b1;
          step(); step(); p_req = '0;
          chk("R5 unselected line ignored", mem_valid, 0);
          k = 0;
          while (m_cnt != 0 && k < 16) begin
            do_xfer((k + sel) % 3, 1'b0, 3'd0, 32'd0);
            k++;
          end
          p_req = '0; p_req[sel] = 1'b1;
          step(); step(); step(); p_req = '0;
          chk("R7 stopped with both counts zero", mem_valid, 0);
          rd(3'd5, v); chk("R8 terminal flag sticky", v[0], 1);
        end

    // R9 interrupt masking
    chk("R9 masked interrupts low", {irq_tc, irq_rld}, 0);
    wr(3'd6, 32'd1);
    chk("R9 terminal interrupt only", {irq_tc, irq_rld}, 2'b10);
    wr(3'd6, 32'd3);
    chk("R9 both interrupts", {irq_tc, irq_rld}, 2'b11);
    wr(3'd1, 32'd3);
    chk("R9 count write clears terminal interrupt", {irq_tc, irq_rld}, 2'b01);
    wr(3'd3, 32'd5);
    chk("R9 standby refill clears interrupt", {irq_tc, irq_rld}, 2'b00);

    // R6 reload while idle: live count written to zero with a standby count pending
    wr(3'd2, 32'h4000);
    wr(3'd1, 32'd0);
    step();
    m_addr = 32'h4000; m_cnt = 5; m_rc = 0;
    check_state("R6 idle reload");

    // R11 collisions on the completion edge
    m_sz = 2; m_dir = 0; m_sel = 1;
    wr(3'd4, {26'd0, 2'd1, 1'b0, 2'd2, 1'b1});
    wr(3'd0, 32'h200);
    wr(3'd1, 32'd3);
    do_xfer(1, 1'b1, 3'd1, 32'd9);
    wr(3'd1, 32'd1);
    wr(3'd2, 32'h900);
    wr(3'd3, 32'd2);
    do_xfer(0, 1'b1, 3'd3, 32'd7);

    report();
  end

endmodule